// File: doc/BRIEF.md
# Operand Effective-Address Generator

This block resolves the operand of one instruction of an 8-bit processor that has a 16-bit address space. The opcode has already been consumed. The block receives an addressing-mode code, the address of the first operand byte, and the two index registers. It then reads the operand bytes through a byte-wide synchronous memory port and follows any pointers the mode calls for. It returns three results: a 16-bit pointer, the 8-bit operand value found at that pointer, and the program counter advanced past the operand bytes. Decoding the opcode and executing the instruction happen elsewhere.

A request is offered on `req_valid` and accepted when `req_ready` is high. `req_ready` is high only while the block is idle, so a requester holding `req_valid` simply waits. Nothing is accepted during an operation. The result is not back-pressured: `done` pulses for one cycle, and the result outputs keep their values until the next request is accepted.

A bypass input, `req_no_deref`, makes the block return the operand field without resolving it. This suits a disassembler, which wants the raw field rather than the data behind it.

Top module: `eff_addr_gen`

## Requirements
- R1: `req_ready` is 1 exactly when the block is idle. A request is taken when `req_valid` and `req_ready` are both 1 at a rising edge, and `req_mode`, `req_no_deref`, `req_pc`, `req_x` and `req_y` are sampled at that edge. `req_valid` during a busy period has no effect on the result in progress.
- R2: After reset, `req_ready`=1, `done`=0 and `mem_rd`=0. `done` is high for exactly one cycle per accepted request. `ptr_out`, `val_out` and `pc_out` are valid while `done` is high and hold their values until the next acceptance.
- R3: Every read drives `mem_rd`=1 with `mem_addr` for one cycle, and `mem_rdata` returns the byte on the following cycle. Each read therefore takes two cycles, and no two reads overlap. No read is issued while idle. `done` follows acceptance by 1 + 2·N cycles, where N is the number of reads.
- R4: Mode codes 0 (accumulator) and 1 (implied), and the unused codes 13–15, perform no reads and give ptr=0, val=0 and pc=req_pc.
- R5: Codes 2 (immediate) and 3 (zero page) read the single byte at req_pc. They give ptr = that byte zero-extended, val = that byte, and pc = req_pc+1.
- R6: Code 4 (absolute) reads a two-byte address low byte first, from req_pc and req_pc+1. Codes 7 and 8 add X or Y to that address, modulo 65536. ptr is the resulting address, val is the byte at ptr, and pc = req_pc+2.
- R7: Codes 9 and 10 add X or Y to the one operand byte as a 16-bit sum with no wrap inside page zero (for example, 0xF0+0x20 gives 0x0110). val is the byte at that sum, and pc = req_pc+1.
- R8: Code 5 (relative) gives ptr = req_pc + 1 + the sign-extended operand byte, modulo 65536. val is the byte at ptr, and pc = req_pc+1.
- R9: Code 6 (indirect) reads a two-byte address A, then the low byte at A and the high byte at A+1 (modulo 65536) to form ptr. val is the byte at ptr, and pc = req_pc+2.
- R10: Code 11 (pre-indexed indirect) adds X to the operand byte as a 16-bit sum S. It reads the pointer low byte at S and the high byte at S+1. val is the byte at that pointer, and pc = req_pc+1.
- R11: Code 12 (post-indexed indirect) reads a base pointer from the operand byte B (low byte) and B+1 (high byte, 0x0100 when B=0xFF), then adds Y modulo 65536 to form ptr. val is the byte at ptr, and pc = req_pc+1.
- R12: With `req_no_deref`=1, no pointer is read and no final data byte is read. Codes 6, 11 and 12 return the raw operand field: the 16-bit address for code 6, and the unindexed byte for codes 11 and 12. Codes 4, 5, 7, 8, 9 and 10 return their computed address. val is the low byte of ptr, and pc advances as without the bypass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle; a request can be taken |
| req_mode | input | 4 | Addressing-mode code |
| req_no_deref | input | 1 | Return the operand field without resolving it |
| req_pc | input | 16 | Address of the first operand byte |
| req_x | input | 8 | X index value |
| req_y | input | 8 | Y index value |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | 16 | Memory read address |
| mem_rdata | input | 8 | Read data, one cycle after the strobe |
| done | output | 1 | One-cycle result strobe |
| ptr_out | output | 16 | Effective address |
| val_out | output | 8 | Operand value |
| pc_out | output | 16 | Program counter past the operand |

## Verification
On every cycle, the assertions check the handshake and port discipline. They confirm that `done` lasts a single cycle and is followed by an idle cycle, that no read overlaps another or occurs while idle, and that the results stay stable while the block sits idle. They also check that the PC never moves by more than two, and that the no-operand modes return zeros with an unchanged PC.

Only the bench scenarios can show that the addresses are correct. These cover little-endian byte order, index carries into the high byte, sign extension of branch offsets, wrap at 0xFFFF, the pointer at 0x00FF reading its high byte from 0x0100, and bypass results. The bench also shows that a request held during a busy period leaves the current result unchanged.

// File: rtl/eag_pkg.sv
package eag_pkg;

  localparam int MODE_W = 4;

  typedef enum logic [MODE_W-1:0] {
    MODE_ACCUM = 4'd0,
    MODE_NONE  = 4'd1,
    MODE_IMM   = 4'd2,
    MODE_ZPG   = 4'd3,
    MODE_ABS   = 4'd4,
    MODE_REL   = 4'd5,
    MODE_IND   = 4'd6,
    MODE_ABSX  = 4'd7,
    MODE_ABSY  = 4'd8,
    MODE_ZPGX  = 4'd9,
    MODE_ZPGY  = 4'd10,
    MODE_PREX  = 4'd11,
    MODE_POSTY = 4'd12
  } eag_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPLO,
    ST_OPHI,
    ST_PLO,
    ST_PHI,
    ST_DATA,
    ST_DONE
  } eag_step_e;

  function automatic logic has_operand(eag_mode_e m);
    return (m inside {MODE_IMM, MODE_ZPG, MODE_ABS, MODE_REL, MODE_IND,
                      MODE_ABSX, MODE_ABSY, MODE_ZPGX, MODE_ZPGY,
                      MODE_PREX, MODE_POSTY});
  endfunction

  function automatic logic uses_x(eag_mode_e m);
    return (m inside {MODE_ABSX, MODE_ZPGX, MODE_PREX});
  endfunction

  function automatic logic uses_y(eag_mode_e m);
    return (m inside {MODE_ABSY, MODE_ZPGY, MODE_POSTY});
  endfunction

endpackage

// File: rtl/eag_index_sel.sv
module eag_index_sel
  import eag_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  eag_mode_e          mode,
  input  logic [DATA_W-1:0]  x_val,
  input  logic [DATA_W-1:0]  y_val,
  output logic [DATA_W-1:0]  idx
);

  always_comb begin
    if (uses_x(mode))      idx = x_val;
    else if (uses_y(mode)) idx = y_val;
    else                   idx = '0;
  end

  // R6
  idx_zero_chk: assert final (uses_x(mode) || uses_y(mode) || idx == '0);

endmodule

// File: rtl/eag_addr_unit.sv
module eag_addr_unit #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic [ADDR_W-1:0] pc_cur,
  input  logic [ADDR_W-1:0] ea_cur,
  input  logic [DATA_W-1:0] lo_byte,
  input  logic [DATA_W-1:0] rd_byte,
  input  logic [DATA_W-1:0] idx,
  output logic [ADDR_W-1:0] byte_ext,
  output logic [ADDR_W-1:0] byte_idx,
  output logic [ADDR_W-1:0] word_raw,
  output logic [ADDR_W-1:0] word_idx,
  output logic [ADDR_W-1:0] rel_tgt,
  output logic [ADDR_W-1:0] ea_next
);

  localparam int EXT_W = ADDR_W - DATA_W;
  localparam int WORD_W = 2 * DATA_W;

  logic [WORD_W-1:0] word_cat;
  logic [ADDR_W-1:0] sext_off;

  assign word_cat = {rd_byte, lo_byte};
  assign sext_off = {{EXT_W{rd_byte[DATA_W-1]}}, rd_byte};

  assign byte_ext = ADDR_W'(rd_byte);
  assign byte_idx = ADDR_W'(rd_byte) + ADDR_W'(idx);
  assign word_raw = ADDR_W'(word_cat);
  assign word_idx = ADDR_W'(word_cat) + ADDR_W'(idx);
  assign rel_tgt  = pc_cur + ADDR_W'(1) + sext_off;
  assign ea_next  = ea_cur + ADDR_W'(1);

endmodule

// File: rtl/eff_addr_gen.sv
module eff_addr_gen
  import eag_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [3:0]        req_mode,
  input  logic              req_no_deref,
  input  logic [ADDR_W-1:0] req_pc,
  input  logic [DATA_W-1:0] req_x,
  input  logic [DATA_W-1:0] req_y,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              done,
  output logic [ADDR_W-1:0] ptr_out,
  output logic [DATA_W-1:0] val_out,
  output logic [ADDR_W-1:0] pc_out
);

  localparam logic [ADDR_W-1:0] PC_STEP = ADDR_W'(1);

  eag_step_e         step_q;
  logic              cap_q;
  eag_mode_e         mode_q;
  logic              nd_q;
  logic [ADDR_W-1:0] pc_q;
  logic [ADDR_W-1:0] pc_base_q;
  logic [DATA_W-1:0] x_q;
  logic [DATA_W-1:0] y_q;
  logic [DATA_W-1:0] lo_q;
  logic [ADDR_W-1:0] ea_q;
  logic [DATA_W-1:0] val_q;

  logic [DATA_W-1:0] idx;
  logic [ADDR_W-1:0] byte_ext, byte_idx, word_raw, word_idx, rel_tgt, ea_next;

  eag_index_sel #(.DATA_W(DATA_W)) u_idx (
    .mode  (mode_q),
    .x_val (x_q),
    .y_val (y_q),
    .idx   (idx)
  );

  eag_addr_unit #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_addr (
    .pc_cur   (pc_q),
    .ea_cur   (ea_q),
    .lo_byte  (lo_q),
    .rd_byte  (mem_rdata),
    .idx      (idx),
    .byte_ext (byte_ext),
    .byte_idx (byte_idx),
    .word_raw (word_raw),
    .word_idx (word_idx),
    .rel_tgt  (rel_tgt),
    .ea_next  (ea_next)
  );

  // Port view of the sequencer
  assign req_ready = (step_q == ST_IDLE);
  assign done      = (step_q == ST_DONE);
  assign ptr_out   = ea_q;
  assign val_out   = val_q;
  assign pc_out    = pc_q;
  assign mem_rd    = !cap_q && (step_q inside {ST_OPLO, ST_OPHI, ST_PLO, ST_PHI, ST_DATA});

  always_comb begin
    case (step_q)
      ST_PLO, ST_DATA: mem_addr = ea_q;
      ST_PHI:          mem_addr = ea_next;
      default:         mem_addr = pc_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q    <= ST_IDLE;
      cap_q     <= 1'b0;
      mode_q    <= MODE_ACCUM;
      nd_q      <= 1'b0;
      pc_q      <= '0;
      pc_base_q <= '0;
      x_q       <= '0;
      y_q       <= '0;
      lo_q      <= '0;
      ea_q      <= '0;
      val_q     <= '0;
    end else begin
      case (step_q)
        ST_IDLE: begin
          cap_q <= 1'b0;
          if (req_valid) begin
            mode_q    <= eag_mode_e'(req_mode);
            nd_q      <= req_no_deref;
            pc_q      <= req_pc;
            pc_base_q <= req_pc;
            x_q       <= req_x;
            y_q       <= req_y;
            if (has_operand(eag_mode_e'(req_mode))) begin
              step_q <= ST_OPLO;
            end else begin
              ea_q   <= '0;
              val_q  <= '0;
              step_q <= ST_DONE;
            end
          end
        end

        ST_OPLO: begin
          if (!cap_q) begin
            cap_q <= 1'b1;
          end else begin
            cap_q <= 1'b0;
            lo_q  <= mem_rdata;
            pc_q  <= pc_q + PC_STEP;
            case (mode_q)
              MODE_IMM, MODE_ZPG: begin
                ea_q   <= byte_ext;
                val_q  <= mem_rdata;
                step_q <= ST_DONE;
              end
              MODE_REL: begin
                ea_q <= rel_tgt;
                if (nd_q) begin
                  val_q  <= rel_tgt[DATA_W-1:0];
                  step_q <= ST_DONE;
                end else begin
                  step_q <= ST_DATA;
                end
              end
              MODE_ZPGX, MODE_ZPGY: begin
                ea_q <= byte_idx;
                if (nd_q) begin
                  val_q  <= byte_idx[DATA_W-1:0];
                  step_q <= ST_DONE;
                end else begin
                  step_q <= ST_DATA;
                end
              end
              MODE_PREX, MODE_POSTY: begin
                if (nd_q) begin
                  ea_q   <= byte_ext;
                  val_q  <= mem_rdata;
                  step_q <= ST_DONE;
                end else begin
                  ea_q   <= (mode_q == MODE_PREX) ? byte_idx : byte_ext;
                  step_q <= ST_PLO;
                end
              end
              default: step_q <= ST_OPHI;
            endcase
          end
        end

        ST_OPHI: begin
          if (!cap_q) begin
            cap_q <= 1'b1;
          end else begin
            cap_q <= 1'b0;
            pc_q  <= pc_q + PC_STEP;
            if (mode_q == MODE_IND) begin
              ea_q <= word_raw;
              if (nd_q) begin
                val_q  <= lo_q;
                step_q <= ST_DONE;
              end else begin
                step_q <= ST_PLO;
              end
            end else begin
              ea_q <= word_idx;
              if (nd_q) begin
                val_q  <= word_idx[DATA_W-1:0];
                step_q <= ST_DONE;
              end else begin
                step_q <= ST_DATA;
              end
            end
          end
        end

        ST_PLO: begin
          if (!cap_q) begin
            cap_q <= 1'b1;
          end else begin
            cap_q  <= 1'b0;
            lo_q   <= mem_rdata;
            step_q <= ST_PHI;
          end
        end

        ST_PHI: begin
          if (!cap_q) begin
            cap_q <= 1'b1;
          end else begin
            cap_q  <= 1'b0;
            ea_q   <= (mode_q == MODE_POSTY) ? word_idx : word_raw;
            step_q <= ST_DATA;
          end
        end

        ST_DATA: begin
          if (!cap_q) begin
            cap_q <= 1'b1;
          end else begin
            cap_q  <= 1'b0;
            val_q  <= mem_rdata;
            step_q <= ST_DONE;
          end
        end

        default: begin
          cap_q  <= 1'b0;
          step_q <= ST_IDLE;
        end
      endcase
    end
  end

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && req_ready));

  // R3
  rd_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> !req_ready && !done);

  // R3
  rd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> !mem_rd);

  // R2
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && !req_valid) |=> ($stable(ptr_out) && $stable(val_out) && $stable(pc_out)));

  // R4
  no_operand_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !has_operand(mode_q)) |-> (ptr_out == '0 && val_out == '0 && pc_out == pc_base_q));

  // R6
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((pc_out - pc_base_q) <= ADDR_W'(2)));

endmodule

// File: tb/eff_addr_gen_tb.sv
module eff_addr_gen_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [3:0]  req_mode = '0;
  logic        req_no_deref = 1'b0;
  logic [15:0] req_pc = '0;
  logic [7:0]  req_x = '0;
  logic [7:0]  req_y = '0;
  logic        mem_rd;
  logic [15:0] mem_addr;
  logic [7:0]  mem_rdata = '0;
  logic        done;
  logic [15:0] ptr_out;
  logic [7:0]  val_out;
  logic [15:0] pc_out;

  int checks = 0;
  int errors = 0;
  int rd_cnt = 0;
  bit busy_exp = 1'b0;
  logic [7:0] memq [int];

  always #2 clk = ~clk;

  eff_addr_gen u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_mode(req_mode), .req_no_deref(req_no_deref), .req_pc(req_pc),
    .req_x(req_x), .req_y(req_y), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .done(done), .ptr_out(ptr_out), .val_out(val_out),
    .pc_out(pc_out)
  );

  function automatic int rdm(int a);
    int k = a & 16'hFFFF;
    if (memq.exists(k)) return int'(memq[k]);
    return ((k & 8'hFF) ^ ((k >> 8) & 8'hFF) ^ 8'hA5);
  endfunction

  always @(posedge clk) if (mem_rd) mem_rdata <= 8'(rdm(int'(mem_addr)));

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  // per-cycle comparison of port discipline
  always @(negedge clk) if (rst_n) begin
    chk("R3", "read while idle", int'(mem_rd && req_ready), 0);
    chk("R2", "unexpected done", int'(done && !busy_exp), 0);
    if (mem_rd) rd_cnt++;
  end

  task automatic model(input int m, input bit nd, input int pc, input int x, input int y,
                       output int ep, output int ev, output int epc, output int nr);
    int a, p, z, off;
    ep = 0; ev = 0; epc = pc; nr = 0;
    case (m)
      2, 3: begin z = rdm(pc); ep = z; ev = z; epc = pc + 1; nr = 1; end
      4, 7, 8: begin
        a = rdm(pc) | (rdm(pc + 1) << 8);
        if (m == 7) a += x;
        if (m == 8) a += y;
        a &= 16'hFFFF; ep = a; epc = pc + 2;
        if (nd) begin ev = a & 8'hFF; nr = 2; end else begin ev = rdm(a); nr = 3; end
      end
      9, 10, 5: begin
        z = rdm(pc); epc = pc + 1;
        if (m == 5) begin off = (z >= 128) ? z - 256 : z; a = (pc + 1 + off) & 16'hFFFF; end
        else a = z + ((m == 9) ? x : y);
        ep = a;
        if (nd) begin ev = a & 8'hFF; nr = 1; end else begin ev = rdm(a); nr = 2; end
      end
      6: begin
        a = rdm(pc) | (rdm(pc + 1) << 8); epc = pc + 2;
        if (nd) begin ep = a; ev = a & 8'hFF; nr = 2; end
        else begin p = rdm(a) | (rdm(a + 1) << 8); ep = p; ev = rdm(p); nr = 5; end
      end
      11, 12: begin
        z = rdm(pc); epc = pc + 1;
        if (nd) begin ep = z; ev = z; nr = 1; end
        else begin
          a = (m == 11) ? z + x : z;
          p = rdm(a) | (rdm(a + 1) << 8);
          if (m == 12) p = (p + y) & 16'hFFFF;
          ep = p; ev = rdm(p); nr = 4;
        end
      end
      default: ;
    endcase
    epc &= 16'hFFFF;
  endtask

  task automatic run_op(string tag, int m, bit nd, int pc, int x, int y, bit intrude);
    int ep, ev, epc, nr, n;
    model(m, nd, pc, x, y, ep, ev, epc, nr);
    @(negedge clk);
    req_valid = 1'b1; req_mode = 4'(m); req_no_deref = nd;
    req_pc = 16'(pc); req_x = 8'(x); req_y = 8'(y);
    busy_exp = 1'b1; rd_cnt = 0;
    @(negedge clk);
    chk("R1", "ready while busy", int'(req_ready), 0);
    if (intrude) begin
      req_pc = 16'h5555; req_mode = 4'd6; req_x = 8'h77; req_y = 8'h66;
    end else req_valid = 1'b0;
    n = 0;
    while (!done && n < 60) begin
      @(negedge clk); n++;
      if (n == 2) req_valid = 1'b0;
      if (!done) chk("R1", "ready while busy", int'(req_ready), 0);
    end
    req_valid = 1'b0;
    chk(tag, "ptr", int'(ptr_out), ep);
    chk(tag, "val", int'(val_out), ev);
    chk(tag, "pc", int'(pc_out), epc);
    chk("R3", "read count", rd_cnt, nr);
    chk("R3", "latency", n, 2 * nr);
    @(negedge clk);
    busy_exp = 1'b0;
    chk("R2", "done width", int'(done), 0);
    chk("R2", "ready after done", int'(req_ready), 1);
    repeat (2) @(negedge clk);
    chk("R2", "ptr held", int'(ptr_out), ep);
    chk("R2", "val held", int'(val_out), ev);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    memq[16'h0600] = 8'h42;
    memq[16'h0700] = 8'h34; memq[16'h0701] = 8'h12; memq[16'h1234] = 8'h9C;
    memq[16'h0710] = 8'hF0; memq[16'h0711] = 8'hFF;
    memq[16'h0720] = 8'hF0;
    memq[16'h0800] = 8'h05; memq[16'h0810] = 8'hFA; memq[16'hFFFE] = 8'h7F;
    memq[16'h0900] = 8'h00; memq[16'h0901] = 8'h30;
    memq[16'h3000] = 8'h78; memq[16'h3001] = 8'h56; memq[16'h5678] = 8'hE1;
    memq[16'h0910] = 8'hFF; memq[16'h0911] = 8'hFF; memq[16'h0000] = 8'h20;
    memq[16'h0A00] = 8'h40; memq[16'h0045] = 8'h00; memq[16'h0046] = 8'h44;
    memq[16'h0A10] = 8'hFF; memq[16'h0100] = 8'h11; memq[16'h0101] = 8'h22;
    memq[16'h0B00] = 8'h80; memq[16'h0080] = 8'hF0; memq[16'h0081] = 8'h20;
    memq[16'h00FF] = 8'hFE;

    repeat (3) @(negedge clk);
    chk("R2", "reset ready", int'(req_ready), 1);
    chk("R2", "reset done", int'(done), 0);
    chk("R3", "reset rd", int'(mem_rd), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 no-operand modes and unused codes
    run_op("R4", 0, 0, 16'h0600, 1, 2, 0);
    run_op("R4", 1, 0, 16'h0601, 1, 2, 0);
    run_op("R4", 14, 0, 16'h0602, 1, 2, 0);
    // R5 single byte operands
    run_op("R5", 2, 0, 16'h0600, 0, 0, 0);
    run_op("R5", 3, 0, 16'h0600, 0, 0, 0);
    // R6 absolute and indexed absolute with wrap
    run_op("R6", 4, 0, 16'h0700, 0, 0, 0);
    run_op("R6", 7, 0, 16'h0700, 8'hF0, 0, 0);
    run_op("R6", 8, 0, 16'h0710, 0, 8'h20, 0);
    // R7 zero-page indexed carries into the high byte
    run_op("R7", 9, 0, 16'h0720, 8'h20, 0, 0);
    run_op("R7", 10, 0, 16'h0720, 0, 8'h03, 0);
    // R8 relative forward, backward, wrap
    run_op("R8", 5, 0, 16'h0800, 0, 0, 0);
    run_op("R8", 5, 0, 16'h0810, 0, 0, 0);
    run_op("R8", 5, 0, 16'hFFFE, 0, 0, 0);
    // R9 indirect, including pointer at 0xFFFF
    run_op("R9", 6, 0, 16'h0900, 0, 0, 0);
    run_op("R9", 6, 0, 16'h0910, 0, 0, 0);
    // R10 pre-indexed indirect
    run_op("R10", 11, 0, 16'h0A00, 8'h05, 0, 0);
    run_op("R10", 11, 0, 16'h0A10, 8'h01, 0, 0);
    // R11 post-indexed indirect, carry and 0xFF base
    run_op("R11", 12, 0, 16'h0B00, 0, 8'h30, 0);
    run_op("R11", 12, 0, 16'h0A10, 0, 8'h02, 0);
    // R12 bypass of dereferencing
    run_op("R12", 4, 1, 16'h0700, 0, 0, 0);
    run_op("R12", 6, 1, 16'h0900, 0, 0, 0);
    run_op("R12", 11, 1, 16'h0A00, 8'h05, 0, 0);
    run_op("R12", 12, 1, 16'h0B00, 0, 8'h30, 0);
    run_op("R12", 9, 1, 16'h0720, 8'h20, 0, 0);
    run_op("R12", 5, 1, 16'h0810, 0, 0, 0);
    // R1 request held during a busy period is ignored
    run_op("R1", 4, 0, 16'h0700, 0, 0, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule